// File: doc/BRIEF.md
# Overhead-Channel HDLC Message Receiver

This block pulls HDLC-framed data link messages out of a single overhead byte that a line framer extracts from every inbound frame. Each time the framer presents that byte with a valid strobe, the block shifts its eight bits out one per clock, most significant bit first. The bit stream goes through a ones-run tracker. This tracker finds flags, drops stuffed zeros and spots aborts. A message controller then packs the surviving data bits into bytes, least significant bit first, and writes them into a message buffer.

When a flag closes a message, the controller checks the CRC-CCITT residue. It also checks the byte count against the length expected for the selected message type. It then raises a sticky interrupt and reports pass or fail on a status bit. Software enables the block, reads the buffer through a read port and clears the interrupt by reading status. A message that arrives while the interrupt is still pending is dropped, so the buffer cannot change while software is reading it.

Top module: `ohdlc_rx`

## Requirements
- R1: While `en_i` is low, overhead bytes are ignored. No message is collected, `irq_o` is not raised, and the receiver returns to flag hunting.
- R2: One overhead byte is taken per accepted `ovh_valid_i` strobe, and its bits are processed MSB first. Strobes must be at least 8 clocks apart; a strobe that arrives while a byte is still shifting out is ignored.
- R3: Bits seen before a first flag (bit pattern 0x7E: a zero, six ones, a zero) are never collected, and a flag that has no message data before it produces no message.
- R4: Inside a message, a zero that directly follows five consecutive ones is removed and not taken as data.
- R5: Seven consecutive ones abort the message. The partial message is discarded, and no message is reported until a new opening flag is seen.
- R6: A flag that follows two or more complete bytes ends the message. The bytes are stored LSB first at buffer addresses 0 upward (readable on `rd_data_o` at `rd_addr_i`), and `msg_len_o` gives the byte count, FCS included.
- R7: `fcs_err_o` is 0 only if two conditions both hold: the CRC-CCITT residue (reflected polynomial 0x8408, preset 0xFFFF, computed over all bytes including the FCS, which is sent low byte first and complemented) equals 0xF0B8, and the byte count equals `LEN_T0` for `msg_type_i`=0 or `LEN_T1` for `msg_type_i`=1. In every other case `fcs_err_o` is 1.
- R8: `irq_o` is set at the end of each message and stays set until a one-cycle `stat_rd_i` pulse clears it. While it is set, incoming messages are dropped, and the buffer contents and `msg_len_o` do not change.
- R9: If a message exceeds `BUF_DEPTH` bytes, it is discarded like an abort, and flag hunting resumes.
- R10: When a flag closes fewer than two data bytes, no message is produced. That same flag opens the next message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Receiver enable |
| ovh_byte_i | input | 8 | Overhead byte from the current line frame |
| ovh_valid_i | input | 1 | Strobe marking `ovh_byte_i` valid |
| msg_type_i | input | 1 | Message type, selects the expected length |
| stat_rd_i | input | 1 | Status read pulse, clears the interrupt |
| rd_addr_i | input | $clog2(BUF_DEPTH) | Buffer read address |
| rd_data_o | output | 8 | Buffer read data (combinational) |
| irq_o | output | 1 | Sticky message-received interrupt |
| fcs_err_o | output | 1 | FCS or length check failed for the last message |
| msg_len_o | output | $clog2(BUF_DEPTH+1) | Byte count of the last message |

## Verification
The bench builds the block with `BUF_DEPTH`=16, `LEN_T0`=6 and `LEN_T1`=10. Messages this short keep every scenario to a few dozen overhead bytes, and a 17-byte message is enough to reach the overflow path. The two small type lengths let both type selections be checked with a correct CRC. They also let a length mismatch be forced while the residue is still good. The test data contains 0xFF and 0x7E/0x3E bytes, so stuffed zeros appear both inside the data and inside the FCS.

// File: rtl/ohdlc_pkg.sv
package ohdlc_pkg;
  typedef enum logic {ST_HUNT, ST_OPEN} rx_state_e;

  localparam logic [15:0] CRC_INIT   = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD   = 16'hF0B8;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;

  // reflected CRC-CCITT, data LSB first
  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/ohdlc_ser.sv
module ohdlc_ser (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [7:0] byte_i,
  input  logic       valid_i,
  output logic       bit_o,
  output logic       bit_vld_o
);
  logic [7:0] sh_q;
  logic [3:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
    end else if (valid_i && cnt_q == 4'd0) begin
      sh_q  <= byte_i;
      cnt_q <= 4'd8;
    end else if (cnt_q != 4'd0) begin
      sh_q  <= {sh_q[6:0], 1'b0};
      cnt_q <= cnt_q - 4'd1;
    end
  end

  assign bit_o     = sh_q[7];
  assign bit_vld_o = (cnt_q != 4'd0);

  a_r2_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_i && cnt_q == 4'd0) |=> (bit_vld_o && bit_o == $past(byte_i[7])));
  a_r2_eight_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 4'd8);
endmodule

// File: rtl/ohdlc_defr.sv
module ohdlc_defr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic bit_i,
  input  logic vld_i,
  output logic flag_o,
  output logic abort_o,
  output logic data_o,
  output logic dbit_o
);
  logic [2:0] ones_q, ones_d;

  always_comb begin
    flag_o  = 1'b0;
    abort_o = 1'b0;
    data_o  = 1'b0;
    ones_d  = ones_q;
    if (vld_i) begin
      if (bit_i) begin
        if (ones_q == 3'd6) begin
          abort_o = 1'b1;
          ones_d  = 3'd7;
        end else if (ones_q != 3'd7) begin
          data_o = 1'b1;
          ones_d = ones_q + 3'd1;
        end
      end else begin
        ones_d = 3'd0;
        if (ones_q == 3'd6)      flag_o = 1'b1;
        else if (ones_q < 3'd5)  data_o = 1'b1;
        // ones_q==5: stuffed zero; ones_q==7: end of abort/idle run
      end
    end
  end

  assign dbit_o = bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ones_q <= '0;
    else if (clr_i) ones_q <= '0;
    else            ones_q <= ones_d;
  end

  a_r4_events_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({flag_o, abort_o, data_o}));
  a_r5_abort_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && !clr_i) |=> !abort_o);
endmodule

// File: rtl/ohdlc_buf.sv
module ohdlc_buf #(
  parameter int DEPTH = 88,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = (int'(raddr_i) < DEPTH) ? mem_q[raddr_i] : 8'h00;

  a_r9_write_in_range: assert property (@(posedge clk_i)
    we_i |-> (int'(waddr_i) < DEPTH));
endmodule

// File: rtl/ohdlc_rx.sv
module ohdlc_rx
  import ohdlc_pkg::*;
#(
  parameter int BUF_DEPTH = 88,
  parameter int LEN_T0    = 76,
  parameter int LEN_T1    = 88,
  localparam int AW       = $clog2(BUF_DEPTH),
  localparam int LW       = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [7:0]    ovh_byte_i,
  input  logic          ovh_valid_i,
  input  logic          msg_type_i,
  input  logic          stat_rd_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic          irq_o,
  output logic          fcs_err_o,
  output logic [LW-1:0] msg_len_o
);
  logic ser_bit, ser_vld;
  logic ev_flag, ev_abort, ev_data, ev_dbit;

  rx_state_e     state_q;
  logic [2:0]    bit_cnt_q;
  logic [6:0]    acc_q;
  logic [LW-1:0] byte_cnt_q, len_q, exp_len;
  logic [15:0]   crc_q;
  logic          irq_q, fcs_err_q;
  logic [7:0]    new_byte;
  logic          byte_done, buf_we;

  ohdlc_ser u_ser (
    .clk_i, .rst_ni, .en_i,
    .byte_i(ovh_byte_i), .valid_i(ovh_valid_i),
    .bit_o(ser_bit), .bit_vld_o(ser_vld)
  );

  ohdlc_defr u_defr (
    .clk_i, .rst_ni, .clr_i(!en_i),
    .bit_i(ser_bit), .vld_i(ser_vld),
    .flag_o(ev_flag), .abort_o(ev_abort), .data_o(ev_data), .dbit_o(ev_dbit)
  );

  assign new_byte  = {ev_dbit, acc_q};
  assign byte_done = en_i && state_q == ST_OPEN && ev_data && bit_cnt_q == 3'd7;
  assign buf_we    = byte_done && byte_cnt_q != LW'(BUF_DEPTH);
  assign exp_len   = msg_type_i ? LW'(LEN_T1) : LW'(LEN_T0);

  ohdlc_buf #(.DEPTH(BUF_DEPTH), .AW(AW)) u_buf (
    .clk_i,
    .we_i(buf_we), .waddr_i(byte_cnt_q[AW-1:0]), .wdata_i(new_byte),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HUNT;
      bit_cnt_q  <= '0;
      acc_q      <= '0;
      byte_cnt_q <= '0;
      crc_q      <= CRC_INIT;
      irq_q      <= 1'b0;
      fcs_err_q  <= 1'b0;
      len_q      <= '0;
    end else begin
      if (stat_rd_i) irq_q <= 1'b0;
      if (!en_i || ev_abort) begin
        state_q <= ST_HUNT;
      end else if (ev_flag) begin
        if (state_q == ST_OPEN && byte_cnt_q >= LW'(2)) begin
          irq_q     <= 1'b1;
          fcs_err_q <= (crc_q != CRC_GOOD) || (bit_cnt_q != 3'd7) || (byte_cnt_q != exp_len);
          len_q     <= byte_cnt_q;
          state_q   <= ST_HUNT;
        end else if (!irq_q) begin
          state_q    <= ST_OPEN;
          bit_cnt_q  <= '0;
          byte_cnt_q <= '0;
          crc_q      <= CRC_INIT;
        end else begin
          state_q <= ST_HUNT;
        end
      end else if (ev_data && state_q == ST_OPEN) begin
        acc_q     <= {ev_dbit, acc_q[6:1]};
        bit_cnt_q <= bit_cnt_q + 3'd1;
        if (bit_cnt_q == 3'd7) begin
          if (byte_cnt_q == LW'(BUF_DEPTH)) begin
            state_q <= ST_HUNT;  // overflow: drop like abort
          end else begin
            crc_q      <= crc_byte(crc_q, new_byte);
            byte_cnt_q <= byte_cnt_q + LW'(1);
          end
        end
      end
    end
  end

  assign irq_o     = irq_q;
  assign fcs_err_o = fcs_err_q;
  assign msg_len_o = len_q;

  a_r8_no_write_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we |-> !irq_q);
  a_r8_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !stat_rd_i) |=> irq_q);
  a_r8_len_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> $stable(len_q));
  a_r6_irq_on_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(ev_flag));
  a_r9_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_cnt_q <= LW'(BUF_DEPTH));
  a_r1_disable_hunt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == ST_HUNT);
endmodule

// File: tb/sim_ohdlc_rx.sv
module sim_ohdlc_rx;
  localparam int CLK_PERIOD = 10;
  localparam int BUF = 16;
  localparam int L0  = 6;
  localparam int L1  = 10;
  localparam int AW  = $clog2(BUF);
  localparam int LW  = $clog2(BUF + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [7:0]    ovh_byte = '0;
  logic          ovh_valid = 1'b0;
  logic          msg_type = 1'b0;
  logic          stat_rd = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          irq, fcs_err;
  logic [LW-1:0] msg_len;

  ohdlc_rx #(.BUF_DEPTH(BUF), .LEN_T0(L0), .LEN_T1(L1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .ovh_byte_i(ovh_byte), .ovh_valid_i(ovh_valid),
    .msg_type_i(msg_type), .stat_rd_i(stat_rd),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq), .fcs_err_o(fcs_err), .msg_len_o(msg_len)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int   n_chk = 0;
  int   n_err = 0;
  logic sb [0:4095];
  int   nb = 0;
  int   ones_run = 0;
  logic [7:0] dat [0:31];
  logic [7:0] img [0:31];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_bit(input logic b);
    sb[nb] = b;
    nb++;
  endtask

  task automatic push_flag();
    push_bit(1'b0);
    for (int i = 0; i < 6; i++) push_bit(1'b1);
    push_bit(1'b0);
    ones_run = 0;
  endtask

  task automatic push_abort();
    for (int i = 0; i < 7; i++) push_bit(1'b1);
    ones_run = 0;
  endtask

  task automatic push_data(input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      push_bit(d[i]);
      if (d[i]) begin
        ones_run++;
        if (ones_run == 5) begin
          push_bit(1'b0);
          ones_run = 0;
        end
      end else ones_run = 0;
    end
  endtask

  // data from dat[0..n-1], FCS appended; image of stored bytes in img
  task automatic push_msg(input int n, input logic bad);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 8; i++) begin
        if (c[0] ^ dat[k][i]) c = (c >> 1) ^ 16'h8408;
        else                  c = c >> 1;
      end
      img[k] = dat[k];
      push_data(dat[k]);
    end
    c = ~c;
    if (bad) c[3] = ~c[3];
    img[n]   = c[7:0];
    img[n+1] = c[15:8];
    push_data(c[7:0]);
    push_data(c[15:8]);
  endtask

  task automatic send_stream();
    logic [7:0] bv;
    while (nb % 8 != 0) push_bit(1'b1);
    for (int k = 0; k < nb / 8; k++) begin
      for (int j = 0; j < 8; j++) bv[7-j] = sb[8*k+j];
      @(negedge clk);
      ovh_byte  = bv;
      ovh_valid = 1'b1;
      @(negedge clk);
      ovh_valid = 1'b0;
      repeat (9) @(negedge clk);
    end
    repeat (12) @(negedge clk);
    nb = 0;
    ones_run = 0;
  endtask

  task automatic status_read();
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_buf(input string tag, input int n);
    for (int a = 0; a < n; a++) begin
      @(negedge clk);
      rd_addr = AW'(a);
      #1;
      chk(tag, int'(rd_data), int'(img[a]));
    end
  endtask

  task automatic set_dat4(input logic [7:0] a, input logic [7:0] b,
                          input logic [7:0] c, input logic [7:0] d);
    dat[0] = a; dat[1] = b; dat[2] = c; dat[3] = d;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R8 reset irq", int'(irq), 0);
    chk("R7 reset fcs_err", int'(fcs_err), 0);
    chk("R6 reset msg_len", int'(msg_len), 0);
  endtask

  task automatic t_disabled();  // R1
    en = 1'b0;
    set_dat4(8'h11, 8'h22, 8'h33, 8'h44);
    push_flag(); push_msg(4, 1'b0); push_flag();
    send_stream();
    chk("R1 disabled no irq", int'(irq), 0);
    en = 1'b1;
  endtask

  task automatic t_no_open();  // R3
    push_data(8'h55); push_data(8'h33); push_flag();
    send_stream();
    chk("R3 no message without opening flag", int'(irq), 0);
  endtask

  task automatic t_good();  // R2 R3 R4 R6 R7
    msg_type = 1'b0;
    set_dat4(8'hFF, 8'h3E, 8'h7E, 8'h81);
    for (int i = 0; i < 8; i++) push_bit(1'b0);
    push_flag(); push_msg(4, 1'b0); push_flag();
    send_stream();
    chk("R6 irq after good message", int'(irq), 1);
    chk("R7 good fcs", int'(fcs_err), 0);
    chk("R6 length", int'(msg_len), L0);
    chk_buf("R4 R2 buffer content", L0);
  endtask

  task automatic t_pending();  // R8
    set_dat4(8'h01, 8'h02, 8'h03, 8'h04);
    push_flag(); push_msg(4, 1'b0); push_flag();
    send_stream();
    chk("R8 irq still set", int'(irq), 1);
    @(negedge clk);
    rd_addr = '0;
    #1;
    chk("R8 buffer kept", int'(rd_data), 8'hFF);
    status_read();
    chk("R8 irq cleared by status read", int'(irq), 0);
  endtask

  task automatic t_bad_fcs();  // R7
    set_dat4(8'hA0, 8'h0B, 8'hC0, 8'h0D);
    push_flag(); push_msg(4, 1'b1); push_flag();
    send_stream();
    chk("R7 bad fcs irq", int'(irq), 1);
    chk("R7 bad fcs flagged", int'(fcs_err), 1);
    status_read();
  endtask

  task automatic t_type_mismatch();  // R7
    msg_type = 1'b1;
    set_dat4(8'h10, 8'h20, 8'h30, 8'h40);
    push_flag(); push_msg(4, 1'b0); push_flag();
    send_stream();
    chk("R7 length mismatch irq", int'(irq), 1);
    chk("R7 length mismatch flagged", int'(fcs_err), 1);
    status_read();
  endtask

  task automatic t_type1();  // R7 R6
    msg_type = 1'b1;
    for (int i = 0; i < 8; i++) dat[i] = 8'(8'hF8 + i);
    push_flag(); push_msg(8, 1'b0); push_flag();
    send_stream();
    chk("R7 type1 irq", int'(irq), 1);
    chk("R7 type1 fcs ok", int'(fcs_err), 0);
    chk("R6 type1 length", int'(msg_len), L1);
    chk_buf("R6 type1 buffer", L1);
    status_read();
    msg_type = 1'b0;
  endtask

  task automatic t_abort();  // R5
    set_dat4(8'h5A, 8'h6B, 8'h7C, 8'h8D);
    push_flag(); push_data(8'h12); push_data(8'h34); push_data(8'h56);
    push_abort(); push_msg(4, 1'b0); push_flag();
    send_stream();
    chk("R5 abort discards message", int'(irq), 0);
    push_flag(); push_msg(4, 1'b0); push_flag();
    send_stream();
    chk("R5 hunt resumes after abort", int'(irq), 1);
    chk("R5 message after abort fcs", int'(fcs_err), 0);
    status_read();
  endtask

  task automatic t_overflow();  // R9
    push_flag();
    for (int i = 0; i < BUF + 1; i++) push_data(8'(i + 1));
    push_flag();
    send_stream();
    chk("R9 overflow discarded", int'(irq), 0);
  endtask

  task automatic t_short();  // R10
    set_dat4(8'hC3, 8'h3C, 8'h99, 8'h66);
    push_flag(); push_data(8'hA5); push_flag();
    push_msg(4, 1'b0); push_flag();
    send_stream();
    chk("R10 shared flag opens next message", int'(irq), 1);
    chk("R10 length", int'(msg_len), L0);
    chk("R10 fcs", int'(fcs_err), 0);
    chk_buf("R10 buffer content", 2);
    status_read();
    push_flag(); push_flag(); push_flag();
    send_stream();
    chk("R10 back-to-back flags no message", int'(irq), 0);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_no_open();
    t_good();
    t_pending();
    t_bad_fcs();
    t_type_mismatch();
    t_type1();
    t_abort();
    t_overflow();
    t_short();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule